// File: doc/BRIEF.md
# Burst-of-Four Read Port Serializer

This block is the read side of a quad-rate burst memory. A requester drives an active-low read select and a shared address. The block samples them only on positive-phase input edges. When it accepts a read, it issues a one-cycle fetch of a 72-bit line from a synchronous array. It then drives that line out as four 18-bit beats, lowest slice first, one beat on each edge of a twice-rate clock. This clock stands in for the double-data-rate output.

The block models time with a single clock that runs at twice the input clock rate. An internal phase bit marks which edges are positive input edges. The first edge after reset is always a positive edge. A burst takes two full input cycles. A read therefore cannot be accepted on the positive edge right after an accepted one. A read issued on every other positive edge keeps the output bus busy without a gap.

When the select is deasserted, the burst in flight runs to its end. The drivers turn off only after that, so the next device on a shared bus can take over without a wait state. The output-enable port stands in for the tri-state drivers. It falls together with the valid flag, and the bus reads zero whenever nothing is driven.

Two finite-state machines do the work, and they share the phase bit. The request machine has these states:
- REQ_IDLE: no fetch is in progress.
- REQ_ISSUE: the array read is asserted.
- REQ_HOLD: the line arrives; this is also the positive edge on which a new request is ignored.
- REQ_GAP: the negative edge before a new request can be accepted.

Its transitions are:
- accept: from REQ_IDLE to REQ_ISSUE, on a positive edge with the select low.
- fetch: from REQ_ISSUE to REQ_HOLD.
- block: from REQ_HOLD to REQ_GAP.
- rearm: from REQ_GAP to REQ_IDLE.

The output machine has these states:
- OUT_OFF: nothing is driven.
- OUT_B0, OUT_B1, OUT_B2 and OUT_B3: the four beats of a burst.

Its transitions are:
- load: from OUT_OFF or OUT_B3 to OUT_B0, when the line is due.
- step: OUT_B0 to OUT_B1, OUT_B1 to OUT_B2, and OUT_B2 to OUT_B3.
- drain: from OUT_B3 to OUT_OFF, when no line is due.

Top module: `rd_burst_serializer`

## Requirements
- R1: After reset, q_oe, q_valid and arr_re are low and q is zero. The first clock edge after reset is a positive-phase edge, and edges then alternate between positive and negative phase.
- R2: When rd_sel_n is low on a positive-phase edge and no read is blocked, the read is accepted. arr_re is then high for exactly one edge interval after that edge, and arr_addr equals the rd_addr sampled at that edge.
- R3: rd_sel_n low on a negative-phase edge starts no read.
- R4: For a read accepted at edge e, beat k is driven on q during the interval after edge e+2+k, for k = 0 to 3. Beat k is bits [18k+17:18k] of the line returned on arr_rdata.
- R5: A request on the positive edge directly after an accepted read is ignored. It produces no arr_re and no burst.
- R6: Reads accepted on every other positive edge give continuous output. q_oe stays high and a new beat appears on every edge.
- R7: After deselect, the pending burst completes. q_oe falls on the edge after the fourth beat.
- R8: q_valid equals q_oe at all times, and q is zero while q_oe is low.
- R9: rd_addr has no effect while rd_sel_n is high. No fetch is made and the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Twice-rate clock; both input phases are its edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read select |
| rd_addr | input | ADDR_W | Read address, sampled with the select |
| arr_re | output | 1 | One-interval array read strobe |
| arr_addr | output | ADDR_W | Address of the array read |
| arr_rdata | input | 4*BEAT_W | Registered line from the array, valid on the edge after arr_re |
| q | output | BEAT_W | Read data beat |
| q_oe | output | 1 | Output drive enable |
| q_valid | output | 1 | A beat is on q |

## Verification
The bench goes after a request held low for two positive edges in a row. A design that fails to block the second request would start an extra fetch and overwrite the line in the middle of a burst. Requests on negative-phase edges are also tried, since a phase-blind design would start reads there. Every-other-edge streams check that the drivers never drop between bursts. A design that returns to idle after every burst would show a one-edge hole in q_oe. Single reads followed by deselect check that the enable falls exactly one edge after the fourth beat, not earlier and not late, and that the beats come out lowest slice first.

// File: rtl/rdser_pkg.sv
package rdser_pkg;
    localparam int BURST_LEN = 4;

    typedef enum logic [1:0] {
        REQ_IDLE,
        REQ_ISSUE,
        REQ_HOLD,
        REQ_GAP
    } req_state_e;

    typedef enum logic [2:0] {
        OUT_OFF,
        OUT_B0,
        OUT_B1,
        OUT_B2,
        OUT_B3
    } out_state_e;
endpackage

// File: rtl/rdser_phase.sv
module rdser_phase (
    input  logic clk,
    input  logic rst_n,
    output logic k_edge
);
    logic ph_q;

    // ph_q low means the coming edge is a positive input edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    assign k_edge = ~ph_q;
endmodule

// File: rtl/rdser_req_fsm.sv
module rdser_req_fsm
    import rdser_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              k_edge,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              arr_re,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              line_due
);
    req_state_e state_q, state_d;
    logic       accept;

    assign accept = k_edge && !sel_n && (state_q == REQ_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE:  if (accept) state_d = REQ_ISSUE;
            REQ_ISSUE: state_d = REQ_HOLD;
            REQ_HOLD:  state_d = REQ_GAP;
            REQ_GAP:   state_d = REQ_IDLE;
            default:   state_d = REQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      arr_addr <= '0;
        else if (accept) arr_addr <= addr;
    end

    always_comb begin
        arr_re   = 1'b0;
        line_due = 1'b0;
        unique case (state_q)
            REQ_IDLE:  ;
            REQ_ISSUE: arr_re = 1'b1;
            REQ_HOLD:  line_due = 1'b1;
            REQ_GAP:   ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/rdser_out_fsm.sv
module rdser_out_fsm
    import rdser_pkg::*;
#(
    parameter int BEAT_W = 18,
    localparam int LINE_W = BEAT_W * BURST_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_due,
    input  logic [LINE_W-1:0] line_in,
    output logic [BEAT_W-1:0] q,
    output logic              q_oe,
    output logic              q_valid
);
    out_state_e        state_q, state_d;
    logic [LINE_W-1:0] line_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_OFF: if (line_due) state_d = OUT_B0;
            OUT_B0:  state_d = OUT_B1;
            OUT_B1:  state_d = OUT_B2;
            OUT_B2:  state_d = OUT_B3;
            OUT_B3:  state_d = line_due ? OUT_B0 : OUT_OFF;
            default: state_d = OUT_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 line_q <= '0;
        else if (state_d == OUT_B0) line_q <= line_in;
    end

    always_comb begin
        q       = '0;
        q_oe    = 1'b1;
        unique case (state_q)
            OUT_OFF: q_oe = 1'b0;
            OUT_B0:  q = line_q[0*BEAT_W +: BEAT_W];
            OUT_B1:  q = line_q[1*BEAT_W +: BEAT_W];
            OUT_B2:  q = line_q[2*BEAT_W +: BEAT_W];
            OUT_B3:  q = line_q[3*BEAT_W +: BEAT_W];
            default: q_oe = 1'b0;
        endcase
        q_valid = q_oe;
    end
endmodule

// File: rtl/rd_burst_serializer.sv
module rd_burst_serializer
    import rdser_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 18,
    localparam int LINE_W = BEAT_W * BURST_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              arr_re,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [LINE_W-1:0] arr_rdata,
    output logic [BEAT_W-1:0] q,
    output logic              q_oe,
    output logic              q_valid
);
    logic k_edge;
    logic line_due;

    rdser_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .k_edge (k_edge)
    );

    rdser_req_fsm #(.ADDR_W(ADDR_W)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .k_edge   (k_edge),
        .sel_n    (rd_sel_n),
        .addr     (rd_addr),
        .arr_re   (arr_re),
        .arr_addr (arr_addr),
        .line_due (line_due)
    );

    rdser_out_fsm #(.BEAT_W(BEAT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_due (line_due),
        .line_in  (arr_rdata),
        .q        (q),
        .q_oe     (q_oe),
        .q_valid  (q_valid)
    );
endmodule

// File: rtl/rd_burst_serializer_chk.sv
module rd_burst_serializer_chk #(
    parameter int BEAT_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              k_edge,
    input logic              arr_re,
    input logic [BEAT_W-1:0] q,
    input logic              q_oe,
    input logic              q_valid
);
    assert_re_one_interval_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_re |=> !arr_re);

    assert_start_on_pos_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_re) |-> $past(k_edge));

    assert_beats_follow_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_re |-> ##2 q_oe);

    assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_re |-> ##2 !arr_re);

    assert_burst_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q_oe) |-> ($past(q_oe, 2) && $past(q_oe, 3) && $past(q_oe, 4)));

    assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !q_oe |-> (q == '0));

    assert_valid_tracks_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid == q_oe);
endmodule

bind rd_burst_serializer rd_burst_serializer_chk #(.BEAT_W(BEAT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .k_edge  (k_edge),
    .arr_re  (arr_re),
    .q       (q),
    .q_oe    (q_oe),
    .q_valid (q_valid)
);

// File: tb/rd_burst_serializer_tb.sv
`timescale 1ns/1ps
module rd_burst_serializer_tb;
    localparam int AW = 18;
    localparam int BW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_sel_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          arr_re;
    logic [AW-1:0] arr_addr;
    logic [4*BW-1:0] arr_rdata = '0;
    logic [BW-1:0] q;
    logic          q_oe, q_valid;

    int checks = 0;
    int fails = 0;
    int edge_n = 0;
    int last_acc = -100;
    bit done = 0;

    logic [BW-1:0] exp_q   [int];
    logic [AW-1:0] exp_re  [int];

    always #5 clk = ~clk;

    rd_burst_serializer #(.ADDR_W(AW), .BEAT_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
        .arr_re(arr_re), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .q(q), .q_oe(q_oe), .q_valid(q_valid)
    );

    function automatic logic [BW-1:0] beat_of(logic [AW-1:0] a, int k);
        return {k[1:0], a[15:0]} ^ 18'h2A5C3;
    endfunction

    function automatic logic [4*BW-1:0] line_of(logic [AW-1:0] a);
        return {beat_of(a, 3), beat_of(a, 2), beat_of(a, 1), beat_of(a, 0)};
    endfunction

    // array model: registered read data
    always @(posedge clk) if (arr_re) arr_rdata <= line_of(arr_addr);

    task automatic check(string tag, bit ok, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s edge %0d %s: actual %h expected %h", tag, edge_n, what, act, exp);
        end
    endtask

    // drive inputs, advance one edge, update model, compare after the edge
    task automatic step(string tag, bit sel_n, logic [AW-1:0] a);
        bit ok;
        logic [BW-1:0] eq;
        rd_sel_n = sel_n;
        rd_addr  = a;
        @(posedge clk);
        if ((edge_n % 2 == 0) && !sel_n && (edge_n - last_acc != 2)) begin
            last_acc = edge_n;
            exp_re[edge_n] = a;
            for (int k = 0; k < 4; k++) exp_q[edge_n + 2 + k] = beat_of(a, k);
        end
        @(negedge clk);
        eq = exp_q.exists(edge_n) ? exp_q[edge_n] : '0;
        ok = (q_oe == exp_q.exists(edge_n)) && (q_valid == q_oe) && (q == eq);
        check(tag, ok, "q_oe/q_valid/q", {12'd0, q_oe, q_valid, q}, {12'd0, exp_q.exists(edge_n), exp_q.exists(edge_n), eq});
        ok = (arr_re == exp_re.exists(edge_n)) &&
             (!exp_re.exists(edge_n) || arr_addr == exp_re[edge_n]);
        check(tag, ok, "arr_re/arr_addr", {13'd0, arr_re, arr_addr},
              {13'd0, exp_re.exists(edge_n), exp_re.exists(edge_n) ? exp_re[edge_n] : arr_addr});
        edge_n++;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", !q_oe && !q_valid && !arr_re && q == '0, "reset outputs",
              {13'd0, q_oe, q_valid, arr_re, q[15:0]}, 32'd0);
        rst_n = 1'b1;

        // R9: address toggling with select high
        for (int i = 0; i < 6; i++) step("R9", 1'b1, AW'(18'h3000 + i * 7));
        // R3: request only on negative-phase edges (odd edges)
        for (int i = 0; i < 4; i++) begin
            step("R3", 1'b1, '0);
            step("R3", 1'b0, AW'(18'h0F0F + i));
        end
        // R2 R4 R7: single read then deselect
        step("R2", 1'b0, 18'h12345);
        step("R4", 1'b1, 18'h3FFFF);
        for (int i = 0; i < 8; i++) step("R7", 1'b1, '0);
        // R5: select held low on consecutive positive edges
        for (int i = 0; i < 12; i++) step("R5", 1'b0, AW'(18'h00A00 + i));
        for (int i = 0; i < 8; i++) step("R5", 1'b1, '0);
        // R6: every other positive edge, continuous output
        for (int i = 0; i < 6; i++) begin
            step("R6", 1'b0, AW'(18'h21000 + i * 3));
            step("R6", 1'b1, '0);
            step("R6", 1'b1, '0);
            step("R6", 1'b1, '0);
        end
        for (int i = 0; i < 8; i++) step("R7", 1'b1, '0);
        // R8 R4: one spare cycle between reads, idle gap observed
        for (int i = 0; i < 3; i++) begin
            step("R8", 1'b0, AW'(18'h05550 + i));
            for (int j = 0; j < 5; j++) step("R8", 1'b1, '0);
        end
        for (int i = 0; i < 6; i++) step("R8", 1'b1, '0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule